// File: doc/BRIEF.md
# USB IN endpoint handshake controller

This block handles one bulk or interrupt IN endpoint of a USB device function. It sits between firmware control bits and the token and handshake signals of a USB serial engine. Firmware puts a packet into a 64-byte buffer and then sets the packet-ready flag. When the serial engine reports an IN token for this endpoint, the block picks one of five outcomes:

- send the buffered bytes,
- send a zero-length data packet,
- answer NAK,
- answer STALL,
- stay silent because the endpoint is switched off.

The data bytes leave through a valid/ready stream that marks the last byte. A data-toggle output gives the packet identifier the engine should use. The block raises a one-cycle interrupt pulse for three events: the host acknowledges a packet, firmware flushes a non-empty buffer, or the block issues a STALL. Each pulse also sets a status flag that firmware can read.

The controller has three states.

- `ST_IDLE` waits for a token.
- `ST_SEND` streams the bytes.
- `ST_WAIT_ACK` holds the sent packet until the host acknowledges it.

The transitions are:

- **idle-to-send:** a token arrives while ready is set and the buffer is non-empty.
- **idle-to-wait:** a token arrives while ready is set and the buffer is empty, so a zero-length packet goes out.
- **send-to-wait:** the last byte is accepted on the stream.
- **wait-to-idle on ack:** the host acknowledges. This commits the transfer.
- **wait-retry:** a token arrives in `ST_WAIT_ACK` without an ack. The block makes the same decision as in idle and resends the same packet with the same toggle.
- **stall-to-idle:** a STALL is issued, from idle or from wait.
- **nak-to-idle:** a NAK is issued.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After synchronous reset, the outputs have these values:
  - `st_en` is 1.
  - `st_ready`, `st_stall`, `st_stall_sent`, `st_irq`, `rsp_valid`, `tx_valid` and `rsp_data1` are all 0.
  - `st_count` is 0.
- R2: A `fw_byte_we` write appends one byte and raises `st_count` by one. The write is ignored while `st_ready` is 1 or while `st_count` is 64.
- R3: An IN token that finds the endpoint enabled, not stalled, ready and with N>0 bytes gives these results:
  - One cycle later, `rsp_valid` is 1 and `rsp_code` is 2 (DATA).
  - The N bytes then stream out in write order, with `tx_last` high only on the last byte.
  - While `tx_ready` is 0, the current byte is held.
- R4: A `host_ack` after a packet has been sent has these effects:
  - `st_ready` and `st_count` clear.
  - `rsp_data1` flips.
  - `irq_pulse` fires.
  - A new token before the ack resends the same bytes with the same `rsp_data1`.
- R5: A token with ready set and an empty buffer gives `rsp_code` 3 (zero-length packet) and no stream beat.
- R6: While `st_stall` is 1, each token gives `rsp_code` 1 (STALL) and no data.
  - Each STALL sets `st_stall_sent` and fires `irq_pulse`.
  - `st_stall_sent` stays 1 until a `fw_stall_sent_clr` pulse.
  - Writing stall as 1 resets `rsp_data1` to 0.
- R7: While `st_en` is 0, a token gives no `rsp_valid` and leaves the buffer untouched.
- R8: A token that finds the endpoint enabled, not stalled and not ready gives `rsp_code` 0 (NAK) and no interrupt.
- R9: A `fw_flush` pulse on a non-empty buffer empties it and fires `irq_pulse`. A flush of an empty buffer fires nothing.
- R10: `irq_pulse` lasts one cycle per event and sets `st_irq`. `st_irq` stays 1 until a `fw_irq_clr` pulse.
- R11: The response priority on a token, from highest, is disabled, then stall, then ready, then NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fw_byte_we | input | 1 | Firmware byte write strobe |
| fw_byte | input | 8 | Byte to append to the buffer |
| fw_ready_set | input | 1 | Pulse that sets packet-ready |
| fw_flush | input | 1 | Pulse that empties the buffer |
| fw_stall_we | input | 1 | Write strobe for the stall control bit |
| fw_stall_val | input | 1 | Value written to the stall control bit |
| fw_en_we | input | 1 | Write strobe for the endpoint enable bit |
| fw_en_val | input | 1 | Value written to the endpoint enable bit |
| fw_stall_sent_clr | input | 1 | Pulse that clears the stall-sent status |
| fw_irq_clr | input | 1 | Pulse that clears the interrupt status |
| tok_in | input | 1 | IN token for this endpoint, one cycle |
| host_ack | input | 1 | Host acknowledged the last data packet |
| tx_ready | input | 1 | Serial engine accepts a data byte |
| rsp_valid | output | 1 | A response is issued this cycle |
| rsp_code | output | 2 | 0 NAK, 1 STALL, 2 DATA, 3 zero-length |
| rsp_data1 | output | 1 | Data toggle: 1 selects DATA1 |
| tx_valid | output | 1 | Data byte valid |
| tx_data | output | 8 | Data byte |
| tx_last | output | 1 | Final byte of the packet |
| irq_pulse | output | 1 | One-cycle endpoint interrupt |
| st_ready | output | 1 | Packet-ready status |
| st_stall | output | 1 | Stall control bit |
| st_en | output | 1 | Endpoint enable bit |
| st_stall_sent | output | 1 | Sticky STALL-issued status |
| st_irq | output | 1 | Sticky interrupt status |
| st_count | output | 7 | Bytes held in the buffer |

## Verification
The response decision is driven through a table of control combinations, and each combination tells a different pair of outcomes apart:

- a three-byte packet and a full 64-byte packet, which separate DATA from the zero-length case;
- not-ready with bytes loaded, which separates NAK from DATA;
- ready with stall set, which shows that stall wins over ready;
- disabled with both stall and ready set, which shows that silence wins over everything.

Directed cases then cover the remaining corners:

- stream back-pressure;
- a retried token before the ack, which must resend the identical bytes and toggle;
- writes while ready or full;
- flush of a full buffer against flush of an empty one;
- the sticky stall and interrupt flags.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
    typedef enum logic [1:0] {
        RSP_NAK   = 2'd0,
        RSP_STALL = 2'd1,
        RSP_DATA  = 2'd2,
        RSP_ZLP   = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SEND     = 2'd1,
        ST_WAIT_ACK = 2'd2
    } ep_state_e;
endpackage

// File: rtl/in_ep_buf.sv
module in_ep_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          clr,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count
);
    logic [DW-1:0] mem [DEPTH];
    logic          full;
    logic          accept;

    assign full    = (count == CW'(DEPTH));
    assign accept  = wr_en && !full;
    assign rd_data = mem[rd_idx];

    // payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[AW'(count)] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (accept) begin
            count <= count + CW'(1);
        end
    end

    // a write into a full buffer must leave the level unchanged
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/in_ep_fsm.sv
module in_ep_fsm
    import usb_in_ep_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          host_ack,
    input  logic          tx_ready,
    input  logic          fw_ready_set,
    input  logic          fw_flush,
    input  logic          fw_stall_we,
    input  logic          fw_stall_val,
    input  logic          fw_en_we,
    input  logic          fw_en_val,
    input  logic          fw_stall_sent_clr,
    input  logic          fw_irq_clr,
    input  logic [CW-1:0] buf_count,
    output logic [AW-1:0] rd_idx,
    output logic          buf_clr,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic          rsp_data1,
    output logic          tx_valid,
    output logic          tx_last,
    output logic          irq_pulse,
    output logic          st_ready,
    output logic          st_stall,
    output logic          st_en,
    output logic          st_stall_sent,
    output logic          st_irq
);
    ep_state_e     state_q, state_d;
    rsp_e          rspc_q, rsp_sel;
    logic          rspv_q, rsp_fire, stall_fire;
    logic          ready_q, stall_q, en_q, ssent_q, tog_q, irq_q, irqp_q;
    logic [AW-1:0] idx_q;
    logic          tok_live, ack_ok, beat, at_end, flush_ok, irq_evt;

    // ---- event decode ----
    always_comb begin
        ack_ok   = host_ack && (state_q == ST_WAIT_ACK);
        tok_live = tok_in && ((state_q == ST_IDLE) ||
                              ((state_q == ST_WAIT_ACK) && !host_ack));
        at_end   = (CW'(idx_q) == (buf_count - CW'(1)));
        beat     = (state_q == ST_SEND) && tx_ready;
        flush_ok = fw_flush && (buf_count != '0) && (state_q != ST_SEND);
        buf_clr  = flush_ok || ack_ok;
    end

    // ---- next-state and response decision ----
    always_comb begin
        state_d    = state_q;
        rsp_fire   = 1'b0;
        rsp_sel    = RSP_NAK;
        stall_fire = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_WAIT_ACK: begin
                if (ack_ok) begin
                    state_d = ST_IDLE;
                end else if (tok_live && en_q) begin
                    rsp_fire = 1'b1;
                    if (stall_q) begin
                        rsp_sel    = RSP_STALL;
                        stall_fire = 1'b1;
                        state_d    = ST_IDLE;
                    end else if (ready_q && (buf_count == '0)) begin
                        rsp_sel = RSP_ZLP;
                        state_d = ST_WAIT_ACK;
                    end else if (ready_q) begin
                        rsp_sel = RSP_DATA;
                        state_d = ST_SEND;
                    end else begin
                        rsp_sel = RSP_NAK;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_SEND: begin
                if (beat && at_end) begin
                    state_d = ST_WAIT_ACK;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        irq_evt = flush_ok || ack_ok || stall_fire;
    end

    // ---- state register ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rspv_q  <= 1'b0;
            rspc_q  <= RSP_NAK;
            ready_q <= 1'b0;
            stall_q <= 1'b0;
            en_q    <= 1'b1;
            ssent_q <= 1'b0;
            tog_q   <= 1'b0;
            irq_q   <= 1'b0;
            irqp_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            rspv_q  <= rsp_fire;
            rspc_q  <= rsp_sel;
            if (state_q != ST_SEND) begin
                idx_q <= '0;
            end else if (beat && !at_end) begin
                idx_q <= idx_q + AW'(1);
            end
            if (ack_ok) begin
                ready_q <= 1'b0;
            end else if (fw_ready_set) begin
                ready_q <= 1'b1;
            end
            if (fw_stall_we) begin
                stall_q <= fw_stall_val;
            end
            if (fw_en_we) begin
                en_q <= fw_en_val;
            end
            if (stall_fire) begin
                ssent_q <= 1'b1;
            end else if (fw_stall_sent_clr) begin
                ssent_q <= 1'b0;
            end
            if (fw_stall_we && fw_stall_val) begin
                tog_q <= 1'b0;
            end else if (ack_ok) begin
                tog_q <= !tog_q;
            end
            irqp_q <= irq_evt;
            if (irq_evt) begin
                irq_q <= 1'b1;
            end else if (fw_irq_clr) begin
                irq_q <= 1'b0;
            end
        end
    end

    // ---- outputs ----
    always_comb begin
        tx_valid      = (state_q == ST_SEND);
        tx_last       = (state_q == ST_SEND) && at_end;
        rd_idx        = idx_q;
        rsp_valid     = rspv_q;
        rsp_code      = rspc_q;
        rsp_data1     = tog_q;
        irq_pulse     = irqp_q;
        st_ready      = ready_q;
        st_stall      = stall_q;
        st_en         = en_q;
        st_stall_sent = ssent_q;
        st_irq        = irq_q;
    end

    assert_stall_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == 2'd1)) |-> (st_stall_sent && irq_pulse));
    assert_hold_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(rd_idx)));
    assert_silent_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && !st_en && !tx_valid) |=> !rsp_valid);
    assert_ready_by_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_ready) |-> $past(host_ack));
    assert_nak_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_code == 2'd0) && !$past(fw_flush)) |-> !irq_pulse);
    assert_irq_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> st_irq);
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fw_byte_we,
    input  logic [DW-1:0] fw_byte,
    input  logic          fw_ready_set,
    input  logic          fw_flush,
    input  logic          fw_stall_we,
    input  logic          fw_stall_val,
    input  logic          fw_en_we,
    input  logic          fw_en_val,
    input  logic          fw_stall_sent_clr,
    input  logic          fw_irq_clr,
    input  logic          tok_in,
    input  logic          host_ack,
    input  logic          tx_ready,
    output logic          rsp_valid,
    output logic [1:0]    rsp_code,
    output logic          rsp_data1,
    output logic          tx_valid,
    output logic [DW-1:0] tx_data,
    output logic          tx_last,
    output logic          irq_pulse,
    output logic          st_ready,
    output logic          st_stall,
    output logic          st_en,
    output logic          st_stall_sent,
    output logic          st_irq,
    output logic [CW-1:0] st_count
);
    logic [AW-1:0] rd_idx;
    logic          buf_clr;
    logic          buf_wr;

    // loading is locked once the packet is handed to hardware
    assign buf_wr = fw_byte_we && !st_ready;

    in_ep_buf #(.DEPTH(DEPTH), .DW(DW)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_data (fw_byte),
        .clr     (buf_clr),
        .rd_idx  (rd_idx),
        .rd_data (tx_data),
        .count   (st_count)
    );

    in_ep_fsm #(.DEPTH(DEPTH)) fsm_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .tok_in            (tok_in),
        .host_ack          (host_ack),
        .tx_ready          (tx_ready),
        .fw_ready_set      (fw_ready_set),
        .fw_flush          (fw_flush),
        .fw_stall_we       (fw_stall_we),
        .fw_stall_val      (fw_stall_val),
        .fw_en_we          (fw_en_we),
        .fw_en_val         (fw_en_val),
        .fw_stall_sent_clr (fw_stall_sent_clr),
        .fw_irq_clr        (fw_irq_clr),
        .buf_count         (st_count),
        .rd_idx            (rd_idx),
        .buf_clr           (buf_clr),
        .rsp_valid         (rsp_valid),
        .rsp_code          (rsp_code),
        .rsp_data1         (rsp_data1),
        .tx_valid          (tx_valid),
        .tx_last           (tx_last),
        .irq_pulse         (irq_pulse),
        .st_ready          (st_ready),
        .st_stall          (st_stall),
        .st_en             (st_en),
        .st_stall_sent     (st_stall_sent),
        .st_irq            (st_irq)
    );
endmodule

// File: tb/usb_in_ep_ctrl_tb_top.sv
`timescale 1ns/1ps
module usb_in_ep_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fw_byte_we, fw_ready_set, fw_flush, fw_stall_we, fw_stall_val;
    logic       fw_en_we, fw_en_val, fw_stall_sent_clr, fw_irq_clr;
    logic [7:0] fw_byte;
    logic       tok_in, host_ack, tx_ready;
    logic       rsp_valid, rsp_data1, tx_valid, tx_last, irq_pulse;
    logic [1:0] rsp_code;
    logic [7:0] tx_data;
    logic       st_ready, st_stall, st_en, st_stall_sent, st_irq;
    logic [6:0] st_count;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    usb_in_ep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .fw_byte_we(fw_byte_we), .fw_byte(fw_byte),
        .fw_ready_set(fw_ready_set), .fw_flush(fw_flush), .fw_stall_we(fw_stall_we),
        .fw_stall_val(fw_stall_val), .fw_en_we(fw_en_we), .fw_en_val(fw_en_val),
        .fw_stall_sent_clr(fw_stall_sent_clr), .fw_irq_clr(fw_irq_clr),
        .tok_in(tok_in), .host_ack(host_ack), .tx_ready(tx_ready),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_data1(rsp_data1),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .irq_pulse(irq_pulse), .st_ready(st_ready), .st_stall(st_stall),
        .st_en(st_en), .st_stall_sent(st_stall_sent), .st_irq(st_irq),
        .st_count(st_count)
    );

    // fields: [13] en [12] stall [11] ready [10:4] bytes [3] rsp_valid [2:1] code [0] irq
    localparam logic [13:0] VEC [0:6] = '{
        {1'b1, 1'b0, 1'b1, 7'd3,  1'b1, 2'd2, 1'b0},   // R3 data packet
        {1'b1, 1'b0, 1'b0, 7'd2,  1'b1, 2'd0, 1'b0},   // R8 nak
        {1'b1, 1'b0, 1'b1, 7'd0,  1'b1, 2'd3, 1'b0},   // R5 zero length
        {1'b1, 1'b1, 1'b1, 7'd2,  1'b1, 2'd1, 1'b1},   // R11 stall over ready
        {1'b0, 1'b1, 1'b1, 7'd1,  1'b0, 2'd0, 1'b0},   // R11 disabled over all
        {1'b1, 1'b0, 1'b1, 7'd64, 1'b1, 2'd2, 1'b0},   // R3 full packet
        {1'b0, 1'b0, 1'b0, 7'd0,  1'b0, 2'd0, 1'b0}    // R7 silent
    };

    function automatic logic [7:0] pat(input int s, input int k);
        return 8'(s * 37 + k + 1);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fw_byte_we = 0; fw_byte = 0; fw_ready_set = 0; fw_flush = 0;
        fw_stall_we = 0; fw_stall_val = 0; fw_en_we = 0; fw_en_val = 0;
        fw_stall_sent_clr = 0; fw_irq_clr = 0; tok_in = 0; host_ack = 0;
        tx_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        fw_byte_we = 1'b1; fw_byte = b;
        @(negedge clk);
        fw_byte_we = 1'b0;
    endtask

    task automatic load(input int n, input int s);
        for (int k = 0; k < n; k++) wr_byte(pat(s, k));
    endtask

    task automatic set_ready();
        fw_ready_set = 1'b1; @(negedge clk); fw_ready_set = 1'b0;
    endtask

    task automatic wr_stall(input logic v);
        fw_stall_we = 1'b1; fw_stall_val = v; @(negedge clk); fw_stall_we = 1'b0;
    endtask

    task automatic wr_en(input logic v);
        fw_en_we = 1'b1; fw_en_val = v; @(negedge clk); fw_en_we = 1'b0;
    endtask

    task automatic token();
        tok_in = 1'b1; @(negedge clk); tok_in = 1'b0;
    endtask

    task automatic ack();
        host_ack = 1'b1; @(negedge clk); host_ack = 1'b0;
    endtask

    task automatic take(input int n, input int s, input string req);
        for (int k = 0; k < n; k++) begin
            chk(req, "tx_valid", 32'(tx_valid), 32'd1);
            chk(req, "tx_data", 32'(tx_data), 32'(pat(s, k)));
            chk(req, "tx_last", 32'(tx_last), 32'(k == n - 1));
            @(negedge clk);
        end
        chk(req, "stream end", 32'(tx_valid), 32'd0);
    endtask

    initial begin
        // ---- table walk ----
        for (int vi = 0; vi < 7; vi++) begin
            logic en, stl, rdy, ev, eirq;
            logic [1:0] ec;
            int n;
            en = VEC[vi][13]; stl = VEC[vi][12]; rdy = VEC[vi][11];
            n = int'(VEC[vi][10:4]); ev = VEC[vi][3]; ec = VEC[vi][2:1]; eirq = VEC[vi][0];
            do_reset();
            if (!en) wr_en(1'b0);
            if (stl) wr_stall(1'b1);
            load(n, vi);
            chk("R2", "count after load", 32'(st_count), 32'(n));
            if (rdy) set_ready();
            token();
            chk("R11", "rsp_valid", 32'(rsp_valid), 32'(ev));
            if (ev) chk("R11", "rsp_code", 32'(rsp_code), 32'(ec));
            chk("R6", "irq on response", 32'(irq_pulse), 32'(eirq));
            if (ev && ec == 2'd2) begin
                take(n, vi, "R3");
                ack();
                chk("R4", "irq on ack", 32'(irq_pulse), 32'd1);
                chk("R4", "ready cleared", 32'(st_ready), 32'd0);
                chk("R4", "count cleared", 32'(st_count), 32'd0);
                chk("R4", "toggle flipped", 32'(rsp_data1), 32'd1);
            end else if (ev && ec == 2'd3) begin
                chk("R5", "no stream", 32'(tx_valid), 32'd0);
                ack();
                chk("R5", "irq on zlp ack", 32'(irq_pulse), 32'd1);
                chk("R5", "toggle flipped", 32'(rsp_data1), 32'd1);
            end else if (ev && ec == 2'd1) begin
                chk("R6", "stall sent", 32'(st_stall_sent), 32'd1);
                chk("R6", "no data", 32'(tx_valid), 32'd0);
            end else begin
                chk("R7", "buffer untouched", 32'(st_count), 32'(n));
                chk("R8", "no stream", 32'(tx_valid), 32'd0);
            end
        end

        // ---- R1 reset state ----
        do_reset();
        chk("R1", "ready", 32'(st_ready), 32'd0);
        chk("R1", "enable", 32'(st_en), 32'd1);
        chk("R1", "stall", 32'(st_stall), 32'd0);
        chk("R1", "stall sent", 32'(st_stall_sent), 32'd0);
        chk("R1", "irq flag", 32'(st_irq), 32'd0);
        chk("R1", "count", 32'(st_count), 32'd0);
        chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1", "tx_valid", 32'(tx_valid), 32'd0);
        chk("R1", "toggle", 32'(rsp_data1), 32'd0);

        // ---- R2 writes ignored while ready or full ----
        load(2, 9);
        set_ready();
        wr_byte(8'hEE);
        chk("R2", "write while ready", 32'(st_count), 32'd2);
        do_reset();
        load(64, 10);
        wr_byte(8'hEE);
        chk("R2", "write while full", 32'(st_count), 32'd64);

        // ---- R3 back-pressure, R4 retry ----
        do_reset();
        load(2, 11);
        set_ready();
        tx_ready = 1'b0;
        token();
        chk("R3", "held valid", 32'(tx_valid), 32'd1);
        chk("R3", "held byte", 32'(tx_data), 32'(pat(11, 0)));
        @(negedge clk);
        chk("R3", "still held", 32'(tx_data), 32'(pat(11, 0)));
        tx_ready = 1'b1;
        @(negedge clk);
        chk("R3", "second byte", 32'(tx_data), 32'(pat(11, 1)));
        chk("R3", "last flag", 32'(tx_last), 32'd1);
        @(negedge clk);
        token();
        chk("R4", "retry rsp", 32'(rsp_code), 32'd2);
        chk("R4", "retry toggle", 32'(rsp_data1), 32'd0);
        take(2, 11, "R4");
        ack();
        chk("R4", "toggle after ack", 32'(rsp_data1), 32'd1);

        // ---- R6 stall resets toggle, sticky flag ----
        wr_stall(1'b1);
        chk("R6", "toggle reset", 32'(rsp_data1), 32'd0);
        token();
        chk("R6", "stall code", 32'(rsp_code), 32'd1);
        wr_stall(1'b0);
        @(negedge clk);
        chk("R6", "stall sent sticky", 32'(st_stall_sent), 32'd1);
        fw_stall_sent_clr = 1'b1; @(negedge clk); fw_stall_sent_clr = 1'b0;
        chk("R6", "stall sent cleared", 32'(st_stall_sent), 32'd0);
        token();
        chk("R8", "nak after stall off", 32'(rsp_code), 32'd0);
        chk("R8", "nak no irq", 32'(irq_pulse), 32'd0);

        // ---- R9 flush, R10 irq flag ----
        do_reset();
        load(3, 12);
        fw_flush = 1'b1; @(negedge clk); fw_flush = 1'b0;
        chk("R9", "flush empties", 32'(st_count), 32'd0);
        chk("R9", "flush irq", 32'(irq_pulse), 32'd1);
        @(negedge clk);
        chk("R10", "pulse one cycle", 32'(irq_pulse), 32'd0);
        repeat (3) @(negedge clk);
        chk("R10", "flag held", 32'(st_irq), 32'd1);
        fw_irq_clr = 1'b1; @(negedge clk); fw_irq_clr = 1'b0;
        chk("R10", "flag cleared", 32'(st_irq), 32'd0);
        fw_flush = 1'b1; @(negedge clk); fw_flush = 1'b0;
        chk("R9", "empty flush no irq", 32'(irq_pulse), 32'd0);
        chk("R9", "empty flush no flag", 32'(st_irq), 32'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL all watchdog act=timeout exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule